// File: doc/BRIEF.md
# One-Second Tick Generator with External Realignment

This block counts cycles of a 2.048 MHz reference clock and emits a short tick once per second. Status counters and software use the tick as a common time base. The period is a parameter, so one second is 2,048,000 reference cycles by default. Each tick is two reference cycles wide.

Several devices can share one second boundary through a sync input. When `sync_dir_out` is low, the block listens on `sync_in`. A rising level on that pin that stays high long enough restarts the second, and the next tick lands one full period later. A floating pin reads high, so a level that simply stays high never counts again. When `sync_dir_out` is high, the block ignores the pin and drives its own tick on `pad_out` for neighbouring devices to follow.

The sync input first passes through two flops. A saturating run counter then qualifies its width. A qualified event reloads the second counter with a value that makes up for this latency.

Top module: `sec_tick_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `tick` and `pad_out` are low. A `sync_in` level that is already high when reset ends is not treated as a sync event.
- R2: Without sync events, `tick` first goes high after the PERIOD-th rising clock edge after reset release. Later rising edges of `tick` follow every PERIOD cycles.
- R3: Every tick is high for exactly PULSE_W (default 2) consecutive cycles. A sync event that arrives during a tick does not shorten it.
- R4: `pad_out` is low whenever `sync_dir_out` is 0. When `sync_dir_out` is 1, `pad_out` equals `tick`.
- R5: With `sync_dir_out` at 0, a sync event is a `sync_in` high level sampled on at least MIN_SYNC (default 2) consecutive rising edges, directly after a low sample. After such an event, `tick` goes high after the PERIOD-th rising edge that follows the edge that first sampled the high level. The tick that was pending on the old schedule does not appear.
- R6: A `sync_in` high that lasts fewer than MIN_SYNC samples has no effect on tick timing.
- R7: A `sync_in` level that stays high produces at most one sync event. Ticks then continue every PERIOD cycles.
- R8: When `sync_dir_out` is 1, `sync_in` is ignored, including qualified-width pulses, and ticks stay on their existing schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2.048 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_dir_out | input | 1 | 0: sync pin is an input; 1: tick driven out, sync pin ignored |
| sync_in | input | 1 | External sync level, asynchronous |
| tick | output | 1 | Once-per-period pulse, PULSE_W cycles wide |
| pad_out | output | 1 | Tick copy for the shared pin, low in input mode |

## Verification
The hardest case to reach from the ports is the gap between a pulse of exactly the minimum width and one that is a single sample short. The two-flop delay hides which edge sampled what. The bench drives `sync_in` on falling edges and counts rising edges from reset release. This makes the sampling edges exact. It predicts the realigned tick edge from the first edge that sees the high level. It also holds `sync_in` high across reset and across whole periods to show that a steady level never fires again.

// File: rtl/sec_tick_timer.sv
module sec_tick_timer #(
  parameter int unsigned PERIOD   = 2048000,
  parameter int unsigned PULSE_W  = 2,
  parameter int unsigned MIN_SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_dir_out,
  input  logic sync_in,
  output logic tick,
  output logic pad_out
);
  localparam int unsigned CW  = $clog2(PERIOD);
  localparam int unsigned PWW = $clog2(PULSE_W + 1);
  localparam int unsigned HW  = $clog2(MIN_SYNC + 1);
  localparam logic [CW-1:0]  LAST    = CW'(PERIOD - 1);
  localparam logic [CW-1:0]  RELOAD  = CW'(MIN_SYNC + 1);
  localparam logic [HW-1:0]  RUN_MAX = HW'(MIN_SYNC);
  localparam logic [HW-1:0]  RUN_HIT = HW'(MIN_SYNC - 1);
  localparam logic [PWW-1:0] PW      = PWW'(PULSE_W);

  logic s1, s2;
  logic [HW-1:0]  hi_run;
  logic [CW-1:0]  cnt;
  logic [PWW-1:0] pulse_left;
  logic qual, wrap;

  assign qual = !sync_dir_out && s2 && (hi_run == RUN_HIT);
  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= sync_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               hi_run <= RUN_MAX;
    else if (!s2)          hi_run <= '0;
    else if (hi_run != RUN_MAX) hi_run <= hi_run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (qual) cnt <= RELOAD;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                     pulse_left <= '0;
    else if (wrap)               pulse_left <= PW;
    else if (pulse_left != '0)   pulse_left <= pulse_left - 1'b1;
  end

  assign tick    = (pulse_left != '0);
  assign pad_out = sync_dir_out & tick;
endmodule

// File: rtl/sec_tick_timer_chk.sv
module sec_tick_timer_chk #(
  parameter int unsigned PERIOD  = 2048000,
  parameter int unsigned PULSE_W = 2
) (
  input logic clk,
  input logic rst,
  input logic sync_dir_out,
  input logic sync_in,
  input logic tick,
  input logic pad_out
);
  localparam int unsigned GW = $clog2(PERIOD + 2) + 1;
  localparam int unsigned RW = $clog2(PULSE_W + 1) + 1;

  logic prev_t, armed, rise;
  logic [GW-1:0] gap;
  logic [RW-1:0] run;

  assign rise = tick && !prev_t;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_t <= 1'b0;
      armed  <= 1'b0;
      gap    <= '0;
      run    <= '0;
    end else begin
      prev_t <= tick;
      if (rise) begin
        gap   <= GW'(1);
        armed <= sync_dir_out;
      end else begin
        if (gap <= GW'(PERIOD)) gap <= gap + 1'b1;
        if (!sync_dir_out) armed <= 1'b0;
      end
      if (!tick)                     run <= '0;
      else if (run < RW'(PULSE_W))   run <= run + 1'b1;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tick);

  a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
    (armed && sync_dir_out && rise) |-> gap == GW'(PERIOD));

  a_r2_not_late: assert property (@(posedge clk) disable iff (rst)
    (armed && sync_dir_out) |-> gap <= GW'(PERIOD));

  a_r3_width_long: assert property (@(posedge clk) disable iff (rst)
    tick |-> run < RW'(PULSE_W));

  a_r3_width_short: assert property (@(posedge clk) disable iff (rst)
    (!tick && run != '0) |-> run == RW'(PULSE_W));

  a_r4_pad_quiet: assert property (@(posedge clk) disable iff (rst)
    !sync_dir_out |-> !pad_out);
endmodule

bind sec_tick_timer sec_tick_timer_chk #(.PERIOD(PERIOD), .PULSE_W(PULSE_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .sync_dir_out(sync_dir_out),
  .sync_in(sync_in),
  .tick(tick),
  .pad_out(pad_out)
);

// File: tb/sec_tick_timer_test.sv
`timescale 1ns/1ps
module sec_tick_timer_test;
  localparam int P = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0;
  logic sync_in = 1'b1;
  logic tick, pad_out;
  int ec = 0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (!rst) ec <= ec + 1;

  sec_tick_timer #(.PERIOD(P), .PULSE_W(2), .MIN_SYNC(2)) uut (
    .clk(clk), .rst(rst), .sync_dir_out(mode), .sync_in(sync_in),
    .tick(tick), .pad_out(pad_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual=%b expected=%b", tag, ec, act, exp);
    end
  endtask

  task automatic step_to(input int n);
    while (ec < n) @(negedge clk);
  endtask

  task automatic tick_window(input int t, input string tag);
    logic early = 1'b0;
    while (ec < t - 1) begin
      @(negedge clk);
      if (tick) early = 1'b1;
    end
    chk({tag, " no tick before window"}, early, 1'b0);
    chk({tag, " low before"}, tick, 1'b0);
    @(negedge clk);
    chk({tag, " first high"}, tick, 1'b1);
    chk({tag, " R4 pad first"}, pad_out, mode);
    @(negedge clk);
    chk({tag, " R3 second high"}, tick, 1'b1);
    chk({tag, " R4 pad second"}, pad_out, mode);
    @(negedge clk);
    chk({tag, " R3 low after two"}, tick, 1'b0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 tick in reset", tick, 1'b0);
    chk("R1 pad in reset", pad_out, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tick after release", tick, 1'b0);
  endtask

  task automatic t_free_run;
    tick_window(P, "R2 R7 first tick");
    tick_window(2 * P, "R2 second tick");
  endtask

  task automatic t_short_pulse;
    sync_in = 1'b0;
    repeat (3) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    tick_window(3 * P, "R6 one-cycle pulse rejected");
  endtask

  task automatic t_resync;
    int c;
    step_to(3 * P + 10);
    c = ec;
    sync_in = 1'b1;
    tick_window(c + P + 1, "R5 realigned tick");
    tick_window(c + 2 * P + 1, "R7 held high no retrigger");
  endtask

  task automatic t_mode_out;
    int base;
    base = ec - 2;
    mode = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    repeat (3) @(negedge clk);
    sync_in = 1'b1;
    repeat (4) @(negedge clk);
    tick_window(base + P, "R8 sync ignored in output mode");
    mode = 1'b0;
  endtask

  task automatic t_min_width;
    int c;
    sync_in = 1'b0;
    repeat (4) @(negedge clk);
    c = ec;
    sync_in = 1'b1;
    repeat (2) @(negedge clk);
    sync_in = 1'b0;
    tick_window(c + P + 1, "R5 minimum-width pulse");
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_short_pulse();
    t_resync();
    t_mode_out();
    t_min_width();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule